// File: doc/BRIEF.md
# Stereo Channel Panning Mixer

This block combines the outputs of two three-channel programmable sound generators and a one-bit beeper into a left and a right sum. Each sound generator has its own 8-bit pan register. The register splits into four 2-bit fields: one for each tone channel and one for the beeper. Each field switches its source on or off for each speaker. There is no fractional gain.

The processor reaches the pan registers through a single byte-wide port. A select input picks the generator whose register a write changes and a read returns. The beeper is routed through both registers, so its loudness depends on how many registers enable it on a side. Channel amplitudes arrive as unsigned 8-bit values. Both sums come out registered and are wide enough that the largest possible total never wraps.

Top module: `stereo_pan_mixer`

## Requirements
- R1: In each pan register, bits 7:6 steer tone channel A, bits 5:4 tone channel B, bits 3:2 tone channel C and bits 1:0 the beeper.
- R2: A 2-bit pan field encodes 2'b00 as silent, 2'b10 as left only, 2'b01 as right only and 2'b11 as both sides.
- R3: A write with `cfg_we` high stores `cfg_wdata` only into the register picked by `psg_sel` (0 = first generator, 1 = second); the other register keeps its value.
- R4: `cfg_rdata` always shows the register currently picked by `psg_sel`.
- R5: Reset clears both registers and both outputs to zero, so every source is silent until it is enabled.
- R6: When `beeper` is high, it adds 255 to a side for each register whose beeper field enables that side. One enabling register gives 255 and two give 510. A low beeper adds nothing.
- R7: Each output is the unsigned sum of every enabled term (up to eight per side) in 11 bits. The full-scale total is 2040 and never wraps.
- R8: The outputs are registered. A change of amplitude, beeper or pan register shows at the outputs one clock edge after it reaches the summing logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psg_sel | input | 1 | Picks which generator's pan register is accessed |
| cfg_we | input | 1 | Write strobe for the pan register port |
| cfg_wdata | input | 8 | Byte written to the selected pan register |
| cfg_rdata | output | 8 | Contents of the selected pan register |
| chan_amp | input | 48 | Six 8-bit tone amplitudes; generator p, channel k (A=0) at bits [(p*3+k)*8 +: 8] |
| beeper | input | 1 | One-bit beeper level |
| left_out | output | 11 | Registered left sum |
| right_out | output | 11 | Registered right sum |

## Verification
A corrupted pan register shows through two paths: at `cfg_rdata` as soon as that generator is selected, and at one or both outputs on the edge after any of its enabled channels carries a nonzero amplitude. A fault in the field decode or in the term gating leaves the register readback correct. It appears only in the sums, one cycle after the affected channel is driven. The checks therefore drive one channel at a time as well as random mixes. A write that leaks into the wrong register shows up at the very next readback of the other register.

// File: rtl/pan_mix_pkg.sv
// Shared definitions for the stereo panning mixer.
// Assumes fields are two bits wide: bit 1 enables left, bit 0 enables right.
package pan_mix_pkg;

    typedef enum logic [1:0] {
        PAN_OFF   = 2'b00,
        PAN_RIGHT = 2'b01,
        PAN_LEFT  = 2'b10,
        PAN_BOTH  = 2'b11
    } pan_field_e;

    localparam int FIELD_W = 2;

    // Left-speaker enable of one pan field
    function automatic logic goes_left(input logic [FIELD_W-1:0] f);
        return f[1];
    endfunction

    // Right-speaker enable of one pan field
    function automatic logic goes_right(input logic [FIELD_W-1:0] f);
        return f[0];
    endfunction

endpackage

// File: rtl/pan_reg_bank.sv
// Pan register bank: one register per sound generator.
// A write lands in the register picked by sel; the read port shows the same register.
// Assumes sel is already within 0..NUM_PSG-1.
module pan_reg_bank #(
    parameter int NUM_PSG = 2,
    parameter int REG_W   = 8,
    localparam int SEL_W  = (NUM_PSG > 1) ? $clog2(NUM_PSG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         sel,
    input  logic                     we,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output logic [NUM_PSG*REG_W-1:0] regs_flat
);

    logic [REG_W-1:0] regs [NUM_PSG];

    generate
        for (genvar p = 0; p < NUM_PSG; p++) begin : g_reg
            // Hold or update this generator's pan register
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[p] <= '0;
                else if (we && (sel == SEL_W'(p)))
                    regs[p] <= wdata;
            end
            assign regs_flat[p*REG_W +: REG_W] = regs[p];
        end
    endgenerate

    // Present the selected register on the read port
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PSG; p++)
            if (sel == SEL_W'(p))
                rdata = regs[p];
    end

endmodule

// File: rtl/pan_gate.sv
// Term gating: turns amplitudes, beeper and pan fields into per-side terms.
// Field k (tone channel k, beeper last) sits at bits [(TONE_CH-k)*2 +: 2],
// so channel A is in the top field and the beeper is in the bottom field.
module pan_gate #(
    parameter int NUM_PSG = 2,
    parameter int TONE_CH = 3,
    parameter int AMP_W   = 8,
    localparam int REG_W  = (TONE_CH + 1) * pan_mix_pkg::FIELD_W,
    localparam int TERMS  = NUM_PSG * (TONE_CH + 1)
) (
    input  logic [NUM_PSG*REG_W-1:0]         regs_flat,
    input  logic [NUM_PSG*TONE_CH*AMP_W-1:0] amp_flat,
    input  logic                             beeper,
    output logic [TERMS*AMP_W-1:0]           left_terms,
    output logic [TERMS*AMP_W-1:0]           right_terms
);
    import pan_mix_pkg::*;

    generate
        for (genvar p = 0; p < NUM_PSG; p++) begin : g_psg
            for (genvar k = 0; k <= TONE_CH; k++) begin : g_src
                localparam int T = p * (TONE_CH + 1) + k;
                logic [FIELD_W-1:0] fld;
                logic [AMP_W-1:0]   src;

                assign fld = regs_flat[p*REG_W + (TONE_CH-k)*FIELD_W +: FIELD_W];

                if (k < TONE_CH) begin : g_tone
                    assign src = amp_flat[(p*TONE_CH + k)*AMP_W +: AMP_W];
                end else begin : g_beep
                    assign src = {AMP_W{beeper}};
                end

                // Pass the source to each side its field enables
                always_comb begin
                    left_terms[T*AMP_W +: AMP_W]  = goes_left(fld)  ? src : '0;
                    right_terms[T*AMP_W +: AMP_W] = goes_right(fld) ? src : '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pan_sum.sv
// Registered adder for one speaker: sums TERMS unsigned terms.
// Assumes OUT_W is wide enough to hold TERMS * (2**AMP_W - 1).
module pan_sum #(
    parameter int TERMS = 8,
    parameter int AMP_W = 8,
    parameter int OUT_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TERMS*AMP_W-1:0] terms,
    output logic [OUT_W-1:0]       total
);

    logic [OUT_W-1:0] acc;

    // Add all terms at full output width
    always_comb begin
        acc = '0;
        for (int t = 0; t < TERMS; t++)
            acc = acc + OUT_W'(terms[t*AMP_W +: AMP_W]);
    end

    // Register the sum
    always_ff @(posedge clk) begin
        if (!rst_n)
            total <= '0;
        else
            total <= acc;
    end

endmodule

// File: rtl/stereo_pan_mixer.sv
// Stereo panning mixer for two three-channel sound generators and a beeper.
// Each generator has a pan register; the beeper is steered by both registers.
// Assumes unsigned amplitudes; outputs are registered, one cycle of latency.
module stereo_pan_mixer #(
    parameter int NUM_PSG  = 2,
    parameter int TONE_CH  = 3,
    parameter int AMP_W    = 8,
    localparam int REG_W   = (TONE_CH + 1) * pan_mix_pkg::FIELD_W,
    localparam int TERMS   = NUM_PSG * (TONE_CH + 1),
    localparam int OUT_W   = AMP_W + $clog2(TERMS),
    localparam int SEL_W   = (NUM_PSG > 1) ? $clog2(NUM_PSG) : 1,
    localparam int AMPS_W  = NUM_PSG * TONE_CH * AMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  psg_sel,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [AMPS_W-1:0] chan_amp,
    input  logic              beeper,
    output logic [OUT_W-1:0]  left_out,
    output logic [OUT_W-1:0]  right_out
);

    logic [NUM_PSG*REG_W-1:0] pan_flat;
    logic [TERMS*AMP_W-1:0]   l_terms;
    logic [TERMS*AMP_W-1:0]   r_terms;

    pan_reg_bank #(.NUM_PSG(NUM_PSG), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (psg_sel),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .regs_flat (pan_flat)
    );

    pan_gate #(.NUM_PSG(NUM_PSG), .TONE_CH(TONE_CH), .AMP_W(AMP_W)) u_gate (
        .regs_flat   (pan_flat),
        .amp_flat    (chan_amp),
        .beeper      (beeper),
        .left_terms  (l_terms),
        .right_terms (r_terms)
    );

    pan_sum #(.TERMS(TERMS), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_sum_l (
        .clk   (clk),
        .rst_n (rst_n),
        .terms (l_terms),
        .total (left_out)
    );

    pan_sum #(.TERMS(TERMS), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_sum_r (
        .clk   (clk),
        .rst_n (rst_n),
        .terms (r_terms),
        .total (right_out)
    );

endmodule

// File: rtl/stereo_pan_mixer_chk.sv
// Property checker for the stereo panning mixer, attached with bind.
// Observes ports and the flattened pan registers; drives nothing.
module stereo_pan_mixer_chk #(
    parameter int NUM_PSG = 2,
    parameter int TONE_CH = 3,
    parameter int AMP_W   = 8,
    localparam int REG_W  = (TONE_CH + 1) * 2,
    localparam int TERMS  = NUM_PSG * (TONE_CH + 1),
    localparam int OUT_W  = AMP_W + $clog2(TERMS),
    localparam int SEL_W  = (NUM_PSG > 1) ? $clog2(NUM_PSG) : 1,
    localparam int AMPS_W = NUM_PSG * TONE_CH * AMP_W,
    localparam int FULL   = TERMS * ((1 << AMP_W) - 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SEL_W-1:0]         psg_sel,
    input logic                     cfg_we,
    input logic [REG_W-1:0]         cfg_wdata,
    input logic [REG_W-1:0]         cfg_rdata,
    input logic [AMPS_W-1:0]        chan_amp,
    input logic                     beeper,
    input logic [NUM_PSG*REG_W-1:0] pan_flat,
    input logic [OUT_W-1:0]         left_out,
    input logic [OUT_W-1:0]         right_out
);

    // R5
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (left_out == '0 && right_out == '0 && pan_flat == '0));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && psg_sel == $past(psg_sel))
            |-> cfg_rdata == $past(cfg_wdata));

    // R2
    all_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pan_flat == '0) |=> (left_out == '0 && right_out == '0));

    // R6
    silent_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_amp == '0 && !beeper) |=> (left_out == '0 && right_out == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(left_out) <= FULL && int'(right_out) <= FULL));

endmodule

bind stereo_pan_mixer stereo_pan_mixer_chk #(
    .NUM_PSG (NUM_PSG),
    .TONE_CH (TONE_CH),
    .AMP_W   (AMP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psg_sel   (psg_sel),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .chan_amp  (chan_amp),
    .beeper    (beeper),
    .pan_flat  (pan_flat),
    .left_out  (left_out),
    .right_out (right_out)
);

// File: tb/stereo_pan_mixer_test.sv
`timescale 1ns/1ps
// Bench for the stereo panning mixer: directed corners plus seeded random mixes.
module stereo_pan_mixer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psg_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [47:0] chan_amp = '0;
    logic        beeper = 1'b0;
    logic [10:0] left_out;
    logic [10:0] right_out;

    int total = 0;
    int bad = 0;
    logic [7:0] m_reg [2];

    always #2.5 clk = ~clk;

    stereo_pan_mixer uut (
        .clk(clk), .rst_n(rst_n), .psg_sel(psg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chan_amp(chan_amp),
        .beeper(beeper), .left_out(left_out), .right_out(right_out)
    );

    // Expected sum for one side (left when lft=1) from the requirements
    function automatic int side_sum(input bit lft, input logic [7:0] r0, input logic [7:0] r1,
                                    input logic [47:0] amps, input logic bp);
        int s = 0;
        for (int p = 0; p < 2; p++) begin
            logic [7:0] r = (p == 0) ? r0 : r1;
            for (int k = 0; k < 4; k++) begin
                logic [1:0] f = r[(3-k)*2 +: 2];
                bit on = lft ? f[1] : f[0];
                int v = (k < 3) ? int'(amps[(p*3+k)*8 +: 8]) : (bp ? 255 : 0);
                if (on) s += v;
            end
        end
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write a pan register through the port and update the model
    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        psg_sel = sel; cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        m_reg[sel] = d;
    endtask

    // Drive sources, let one edge pass, compare both outputs
    task automatic drive(input string req, input logic [47:0] a, input logic b);
        @(negedge clk);
        chan_amp = a; beeper = b;
        @(posedge clk);
        @(negedge clk);
        check({req, " left"},  int'(left_out),  side_sum(1'b1, m_reg[0], m_reg[1], a, b));
        check({req, " right"}, int'(right_out), side_sum(1'b0, m_reg[0], m_reg[1], a, b));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_reg[0] = '0; m_reg[1] = '0;
        chan_amp = {6{8'hFF}}; beeper = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: outputs and registers clear after reset, even with loud inputs
        check("R5 left", int'(left_out), 0);
        check("R5 right", int'(right_out), 0);
        psg_sel = 1'b0; #0.1 check("R5 reg0", int'(cfg_rdata), 0);
        psg_sel = 1'b1; #0.1 check("R5 reg1", int'(cfg_rdata), 0);
        drive("R5 silent", {6{8'hFF}}, 1'b1);

        // R1/R2: each field, each code, one source at a time
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 3; k++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [47:0] a = '0;
                    a[(p*3+k)*8 +: 8] = 8'(37 + 20*k + 60*p);
                    wr(p[0], 8'(c << ((3-k)*2)));
                    drive($sformatf("R1 R2 psg%0d ch%0d code%0d", p, k, c), a, 1'b0);
                end
                wr(p[0], 8'h00);
            end
        end

        // R6: beeper alone, single and double enable, high and low
        wr(1'b0, 8'b0000_0011); wr(1'b1, 8'b0000_0000);
        drive("R6 one reg", '0, 1'b1);
        check("R6 one reg 255", int'(left_out), 255);
        wr(1'b1, 8'b0000_0011);
        drive("R6 two regs", '0, 1'b1);
        check("R6 two regs 510", int'(right_out), 510);
        wr(1'b1, 8'b0000_0010);
        drive("R6 split pan", '0, 1'b1);
        drive("R6 beeper low", '0, 1'b0);

        // R3/R4: a write to one register leaves the other unchanged
        wr(1'b0, 8'hA5);
        wr(1'b1, 8'h3C);
        @(negedge clk); psg_sel = 1'b0; #0.1 check("R4 read reg0", int'(cfg_rdata), 'hA5);
        psg_sel = 1'b1; #0.1 check("R3 reg1 kept", int'(cfg_rdata), 'h3C);
        wr(1'b1, 8'h81);
        @(negedge clk); psg_sel = 1'b0; #0.1 check("R3 reg0 kept", int'(cfg_rdata), 'hA5);

        // R7: full scale on both sides
        wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
        drive("R7 full", {6{8'hFF}}, 1'b1);
        check("R7 full 2040", int'(left_out), 2040);

        // R8: output follows a source change after exactly one edge
        @(negedge clk);
        chan_amp = {40'd0, 8'd9}; beeper = 1'b0;
        check("R8 before edge", int'(left_out), 2040);
        @(posedge clk); @(negedge clk);
        check("R8 after edge", int'(left_out), 9);

        // R7: random mixes of pan settings and sources
        for (int i = 0; i < 300; i++) begin
            logic [47:0] a;
            if (i % 10 == 0) wr(1'($urandom), 8'($urandom));
            a = {$urandom, $urandom};
            drive("R7 random", a, 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule